// File: doc/BRIEF.md
# Mode-Dependent Instruction Byte Classifier

This block sits at the front of an x86 instruction path. It takes an instruction byte stream one byte per cycle through a valid/ready handshake and produces one record for each instruction. A mode input selects how the bytes are read: 64-bit mode, or legacy/compatibility (32-bit) mode. Some byte values change meaning with the mode. In one mode a byte may be a prefix, in the other an instruction, and in a third case it may be an illegal opcode. The classifier settles which meaning applies and reports it.

Each record carries:
- the operand-size and address-size prefix flags;
- the REX prefix presence and its W/R/X/B bits;
- the opcode byte, and whether it came after the 0x0F escape;
- a class code;
- the total length in bytes;
- an undefined-opcode fault flag.

Only a chosen set of opcodes is classified. These are the single-byte opcodes that change with the mode, plus a few encodings that are the same in both modes. Every other opcode is reported as class 0 with no fault, and its length counts the opcode byte only. A later stage uses the record to decide whether to raise the fault and how far to advance.

A synchronous `flush` input discards any partly collected instruction and any record still waiting. The `lahf_en` input decides whether the flag-transfer opcodes are legal in 64-bit mode.

Top module: `x86_mode_classifier`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: In 64-bit mode, bytes 0x40..0x4F are taken as a REX prefix, not as an instruction. The record for the next opcode has `out_rex`=1 and `out_wrxb` equal to the low nibble of that byte (bit 3 W, bit 0 B). A REX byte adds 1 to the length. When REX.B=1, opcode 0x90 is class 0.
- R3: In 32-bit mode, bytes 0x40..0x4F are single-byte increment/decrement register instructions. They give class 1, length 1 plus any prefixes, and `out_rex`=0.
- R4: Bytes 0x66 and 0x67 set `out_opsz` and `out_adsz` and never change the mode. In 64-bit mode, 66 40 90 forms one record: class 2 (NOP), length 3, `out_opsz`=1, `out_rex`=1, `out_wrxb`=0.
- R5: A REX byte counts only when it comes directly before the opcode. If a 0x66 or 0x67 follows a REX byte, that REX is discarded (`out_rex`=0, `out_wrxb`=0), but its byte still counts in the length.
- R6: Opcode 0x63 takes one ModRM byte, which counts in the length. It is class 5 in 32-bit mode. In 64-bit mode it is class 6 (sign-extending) when REX.W=1 and class 7 when REX.W=0.
- R7: Opcodes 0x06, 0x07, 0x0E, 0x16, 0x17, 0x1E and 0x1F are class 8. In 64-bit mode they set `out_ud` and end at the opcode byte. In 32-bit mode they are valid.
- R8: Sequences 0F A0, 0F A1, 0F A8 and 0F A9 are class 9 in both modes. They give `out_esc`=1, `out_opcode` equal to the second byte, `out_ud`=0 and length 2. Any other byte after 0x0F gives class 0 with `out_esc`=1.
- R9: Opcodes 0x27, 0x2F, 0x37, 0x3F, 0xD4 and 0xD5 are class 10. In 64-bit mode they set `out_ud` and end at the opcode byte. In 32-bit mode they are valid, and 0xD4/0xD5 take one immediate byte.
- R10: Opcode 0xFF takes a ModRM byte. If its bits 5:3 are 0, the record is class 4; otherwise it is class 0. Either way the length is 2 with no prefixes and the record is valid in both modes.
- R11: Opcodes 0xB8..0xBF are class 3 and are followed by an immediate. The immediate is 4 bytes by default, 2 bytes after 0x66, and 8 bytes when REX.W=1 in 64-bit mode. B8 39 30 00 00 has length 5 in both modes.
- R12: Opcodes 0x9E and 0x9F are class 11. They are valid in 32-bit mode. In 64-bit mode they set `out_ud` unless `lahf_en` is 1.
- R13: When `flush` is 1 at a clock edge, the partly collected instruction and any pending record are dropped. `out_valid` is 0 after that edge, and the next instruction carries no leftover prefix or length.
- R14: While `out_valid` is 1, `in_ready` is 0. While `out_ready` is 0, the record stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard partial instruction and pending record |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit legacy/compatibility mode |
| lahf_en | input | 1 | Allow opcodes 0x9E/0x9F in 64-bit mode |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Classifier accepts a byte this cycle |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | Primary opcode byte (second byte after 0x0F) |
| out_esc | output | 1 | Opcode came after the 0x0F escape |
| out_class | output | 4 | Class code |
| out_len | output | 4 | Instruction length in bytes |
| out_ud | output | 1 | Undefined-opcode fault |
| out_opsz | output | 1 | Operand-size prefix seen |
| out_adsz | output | 1 | Address-size prefix seen |
| out_rex | output | 1 | REX prefix in effect |
| out_wrxb | output | 4 | REX W/R/X/B bits |

## Verification
The assertions assume three things about the inputs:
- `mode64` does not change while an instruction is being collected;
- an instruction never has more than 15 bytes, so the length field does not wrap;
- a ModRM byte is always the register form, so no displacement follows it.

The stimulus follows these rules. It changes `mode64` and `lahf_en` only while the input is idle and no record is pending. Its longest instruction is the 10-byte immediate move. Its ModRM bytes all use the register form (0xC0..0xFF). It asserts `flush` only in cycles where `in_valid` is low.

// File: rtl/xmc_pkg.sv
// Shared types for the mode-dependent instruction byte classifier.
// Assumes byte-wide input; the length field covers legal x86 lengths (<= 15).
package xmc_pkg;

    localparam int BYTE_W  = 8;
    localparam int LEN_W   = 4;
    localparam int CLASS_W = 4;

    typedef enum logic [CLASS_W-1:0] {
        CL_OTHER    = 4'd0,
        CL_INCDEC   = 4'd1,
        CL_NOP      = 4'd2,
        CL_MOV_IMM  = 4'd3,
        CL_INC_RM   = 4'd4,
        CL_ARPL     = 4'd5,
        CL_MOVSXD   = 4'd6,
        CL_MOVD     = 4'd7,
        CL_SEG_PP   = 4'd8,
        CL_FSGS_PP  = 4'd9,
        CL_BCD      = 4'd10,
        CL_FLAGS_AH = 4'd11
    } op_class_e;

    typedef enum logic [1:0] {
        ST_PFX,
        ST_ESC,
        ST_MODRM,
        ST_IMM
    } col_state_e;

    // Lookup result for a first opcode byte
    typedef struct packed {
        logic             ud;
        op_class_e        cls;
        logic             need_modrm;
        logic [LEN_W-1:0] imm_len;
    } op_info_t;

    // One finished instruction record
    typedef struct packed {
        logic [BYTE_W-1:0] opcode;
        logic              esc;
        op_class_e         cls;
        logic [LEN_W-1:0]  len;
        logic              ud;
        logic              opsz;
        logic              adsz;
        logic              rex;
        logic [3:0]        wrxb;
    } rec_t;

    // Second bytes after 0x0F that push/pop FS or GS
    function automatic logic is_fsgs(input logic [BYTE_W-1:0] b);
        return (b == 8'hA0) || (b == 8'hA1) || (b == 8'hA8) || (b == 8'hA9);
    endfunction

endpackage

// File: rtl/xmc_prefix_sort.sv
// Sorts one input byte into prefix kinds.
// Only 0x66/0x67 are legacy prefixes here; 0x40..0x4F are REX only in 64-bit mode.
module xmc_prefix_sort
    import xmc_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              mode64_i,
    output logic              is_opsz_o,
    output logic              is_adsz_o,
    output logic              is_rex_o
);

    // Decode the prefix kind of the current byte
    always_comb begin
        is_opsz_o = (byte_i == 8'h66);
        is_adsz_o = (byte_i == 8'h67);
        is_rex_o  = mode64_i && (byte_i[7:4] == 4'h4);
    end

endmodule

// File: rtl/xmc_opclass.sv
// Classifies a first opcode byte under the current mode and prefixes.
// Gives class, fault, whether a ModRM byte follows and the immediate size.
// 0xFF is refined later from its ModRM reg field; 0x0F is handled by the caller.
module xmc_opclass
    import xmc_pkg::*;
#(
    parameter int N_SEG = 7,
    parameter int N_BCD = 6
) (
    input  logic [BYTE_W-1:0] opc_i,
    input  logic              mode64_i,
    input  logic              lahf_en_i,
    input  logic              rex_w_i,
    input  logic              rex_b_i,
    input  logic              opsz_i,
    output op_info_t          info_o
);

    localparam logic [BYTE_W-1:0] SEG_OPS [N_SEG] =
        '{8'h0E, 8'h1E, 8'h1F, 8'h06, 8'h07, 8'h16, 8'h17};
    localparam logic [BYTE_W-1:0] BCD_OPS [N_BCD] =
        '{8'hD5, 8'h37, 8'h27, 8'hD4, 8'h3F, 8'h2F};
    localparam logic [LEN_W-1:0] IMM_WIDE = LEN_W'(8);
    localparam logic [LEN_W-1:0] IMM_WORD = LEN_W'(2);
    localparam logic [LEN_W-1:0] IMM_DW   = LEN_W'(4);

    logic seg_hit;
    logic bcd_hit;

    // Match against the segment push/pop and decimal-adjust opcode lists
    always_comb begin
        seg_hit = 1'b0;
        bcd_hit = 1'b0;
        for (int i = 0; i < N_SEG; i++) seg_hit |= (opc_i == SEG_OPS[i]);
        for (int i = 0; i < N_BCD; i++) bcd_hit |= (opc_i == BCD_OPS[i]);
    end

    // Pick class, fault and trailing-byte needs
    always_comb begin
        info_o            = '0;
        info_o.cls        = CL_OTHER;
        if (!mode64_i && opc_i[7:4] == 4'h4) begin
            info_o.cls = CL_INCDEC;
        end else if (opc_i == 8'h90) begin
            info_o.cls = rex_b_i ? CL_OTHER : CL_NOP;
        end else if (opc_i[7:3] == 5'b10111) begin
            info_o.cls     = CL_MOV_IMM;
            info_o.imm_len = rex_w_i ? IMM_WIDE : (opsz_i ? IMM_WORD : IMM_DW);
        end else if (opc_i == 8'hFF) begin
            info_o.need_modrm = 1'b1;
        end else if (opc_i == 8'h63) begin
            info_o.need_modrm = 1'b1;
            info_o.cls = !mode64_i ? CL_ARPL : (rex_w_i ? CL_MOVSXD : CL_MOVD);
        end else if (seg_hit) begin
            info_o.cls = CL_SEG_PP;
            info_o.ud  = mode64_i;
        end else if (bcd_hit) begin
            info_o.cls = CL_BCD;
            info_o.ud  = mode64_i;
            if (!mode64_i && opc_i[7:4] == 4'hD) info_o.imm_len = LEN_W'(1);
        end else if (opc_i == 8'h9E || opc_i == 8'h9F) begin
            info_o.cls = CL_FLAGS_AH;
            info_o.ud  = mode64_i && !lahf_en_i;
        end
    end

endmodule

// File: rtl/xmc_collect.sv
// Collects prefixes, opcode, ModRM and immediate bytes of one instruction.
// Pulses emit_o with the finished record on its last byte.
// Assumes the mode is stable within an instruction and a ModRM byte has no displacement.
module xmc_collect
    import xmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              is_opsz_i,
    input  logic              is_adsz_i,
    input  logic              is_rex_i,
    input  op_info_t          info_i,
    output logic              cur_opsz_o,
    output logic [3:0]        cur_wrxb_o,
    output logic              emit_o,
    output rec_t              rec_o
);

    col_state_e        st_q, st_d;
    logic              opsz_q, opsz_d, adsz_q, adsz_d, rex_q, rex_d;
    logic [3:0]        wrxb_q, wrxb_d;
    logic [BYTE_W-1:0] opc_q, opc_d;
    logic              esc_q, esc_d, ud_q, ud_d;
    op_class_e         cls_q, cls_d;
    logic [LEN_W-1:0]  len_q, len_d, cnt_q, cnt_d;

    assign cur_opsz_o = opsz_q;
    assign cur_wrxb_o = wrxb_q;

    // Next-state logic for one accepted byte, and the record it may finish
    always_comb begin
        st_d   = st_q;   opsz_d = opsz_q; adsz_d = adsz_q; rex_d = rex_q;
        wrxb_d = wrxb_q; opc_d  = opc_q;  esc_d  = esc_q;  ud_d  = ud_q;
        cls_d  = cls_q;  len_d  = len_q;  cnt_d  = cnt_q;  emit_o = 1'b0;
        if (take_i) begin
            len_d = len_q + LEN_W'(1);
            unique case (st_q)
                ST_PFX: begin
                    if (is_opsz_i || is_adsz_i) begin
                        opsz_d = opsz_q | is_opsz_i;
                        adsz_d = adsz_q | is_adsz_i;
                        rex_d  = 1'b0;
                        wrxb_d = 4'b0;
                    end else if (is_rex_i) begin
                        rex_d  = 1'b1;
                        wrxb_d = byte_i[3:0];
                    end else begin
                        opc_d = byte_i;
                        if (byte_i == 8'h0F) begin
                            st_d = ST_ESC;
                        end else begin
                            cls_d = info_i.cls;
                            ud_d  = info_i.ud;
                            if (info_i.ud) begin
                                emit_o = 1'b1;
                            end else if (info_i.need_modrm) begin
                                st_d = ST_MODRM;
                            end else if (info_i.imm_len != '0) begin
                                st_d  = ST_IMM;
                                cnt_d = info_i.imm_len;
                            end else begin
                                emit_o = 1'b1;
                            end
                        end
                    end
                end
                ST_ESC: begin
                    esc_d  = 1'b1;
                    opc_d  = byte_i;
                    cls_d  = is_fsgs(byte_i) ? CL_FSGS_PP : CL_OTHER;
                    emit_o = 1'b1;
                end
                ST_MODRM: begin
                    if (opc_q == 8'hFF)
                        cls_d = (byte_i[5:3] == 3'b000) ? CL_INC_RM : CL_OTHER;
                    emit_o = 1'b1;
                end
                ST_IMM: begin
                    cnt_d = cnt_q - LEN_W'(1);
                    if (cnt_q == LEN_W'(1)) emit_o = 1'b1;
                end
                default: st_d = ST_PFX;
            endcase
        end
        rec_o = '{opcode: opc_d, esc: esc_d, cls: cls_d, len: len_d, ud: ud_d,
                  opsz: opsz_d, adsz: adsz_d, rex: rex_d, wrxb: wrxb_d};
        if (emit_o || flush_i) begin
            st_d   = ST_PFX; opsz_d = 1'b0; adsz_d = 1'b0; rex_d = 1'b0;
            wrxb_d = 4'b0;   opc_d  = '0;   esc_d  = 1'b0; ud_d  = 1'b0;
            cls_d  = CL_OTHER; len_d = '0;  cnt_d  = '0;
        end
    end

    // Register the collection state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_PFX; opsz_q <= 1'b0; adsz_q <= 1'b0; rex_q <= 1'b0;
            wrxb_q <= 4'b0;   opc_q  <= '0;   esc_q  <= 1'b0; ud_q  <= 1'b0;
            cls_q  <= CL_OTHER; len_q <= '0;  cnt_q  <= '0;
        end else begin
            st_q   <= st_d;   opsz_q <= opsz_d; adsz_q <= adsz_d; rex_q <= rex_d;
            wrxb_q <= wrxb_d; opc_q  <= opc_d;  esc_q  <= esc_d;  ud_q  <= ud_d;
            cls_q  <= cls_d;  len_q  <= len_d;  cnt_q  <= cnt_d;
        end
    end

endmodule

// File: rtl/xmc_rec_hold.sv
// One-entry output stage: holds a record until the consumer takes it.
// Input is accepted only while empty, so an emit never meets a full stage.
module xmc_rec_hold
    import xmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic emit_i,
    input  rec_t rec_i,
    input  logic out_ready_i,
    output logic out_valid_o,
    output logic in_ready_o,
    output rec_t rec_o
);

    logic valid_q;
    rec_t rec_q;

    assign out_valid_o = valid_q;
    assign in_ready_o  = !valid_q;
    assign rec_o       = rec_q;

    // Load on emit, drop on take or flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            valid_q <= 1'b0;
            rec_q   <= '0;
        end else if (emit_i) begin
            valid_q <= 1'b1;
            rec_q   <= rec_i;
        end else if (out_ready_i) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/x86_mode_classifier.sv
// Top level: mode-dependent instruction byte classifier.
// Takes one byte per cycle and emits one record per instruction.
// Assumes mode64 and lahf_en change only between instructions.
module x86_mode_classifier
    import xmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              mode64,
    input  logic              lahf_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_opcode,
    output logic              out_esc,
    output logic [CLASS_W-1:0] out_class,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_ud,
    output logic              out_opsz,
    output logic              out_adsz,
    output logic              out_rex,
    output logic [3:0]        out_wrxb
);

    logic     is_opsz, is_adsz, is_rex, take, emit, cur_opsz;
    logic [3:0] cur_wrxb;
    op_info_t info;
    rec_t     rec_new, rec_out;

    assign take = in_valid && in_ready && !flush;

    xmc_prefix_sort u_sort (
        .byte_i    (in_byte),
        .mode64_i  (mode64),
        .is_opsz_o (is_opsz),
        .is_adsz_o (is_adsz),
        .is_rex_o  (is_rex)
    );

    xmc_opclass u_class (
        .opc_i     (in_byte),
        .mode64_i  (mode64),
        .lahf_en_i (lahf_en),
        .rex_w_i   (cur_wrxb[3]),
        .rex_b_i   (cur_wrxb[0]),
        .opsz_i    (cur_opsz),
        .info_o    (info)
    );

    xmc_collect u_coll (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush),
        .take_i     (take),
        .byte_i     (in_byte),
        .is_opsz_i  (is_opsz),
        .is_adsz_i  (is_adsz),
        .is_rex_i   (is_rex),
        .info_i     (info),
        .cur_opsz_o (cur_opsz),
        .cur_wrxb_o (cur_wrxb),
        .emit_o     (emit),
        .rec_o      (rec_new)
    );

    xmc_rec_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush),
        .emit_i      (emit),
        .rec_i       (rec_new),
        .out_ready_i (out_ready),
        .out_valid_o (out_valid),
        .in_ready_o  (in_ready),
        .rec_o       (rec_out)
    );

    assign out_opcode = rec_out.opcode;
    assign out_esc    = rec_out.esc;
    assign out_class  = rec_out.cls;
    assign out_len    = rec_out.len;
    assign out_ud     = rec_out.ud;
    assign out_opsz   = rec_out.opsz;
    assign out_adsz   = rec_out.adsz;
    assign out_rex    = rec_out.rex;
    assign out_wrxb   = rec_out.wrxb;

endmodule

// File: rtl/xmc_chk.sv
// Property checker for the classifier's record port, bound to the top level.
module xmc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       mode64,
    input logic       lahf_en,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_opcode,
    input logic       out_esc,
    input logic [3:0] out_class,
    input logic [3:0] out_len,
    input logic       out_ud,
    input logic       out_rex
);

    // R14
    held_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=>
            (out_valid && $stable(out_opcode) && $stable(out_class) && $stable(out_len)));

    // R14
    no_take_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R13
    flush_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R2
    rex_only_64_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rex) |-> mode64);

    // R3
    incdec_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 4'd1) |-> (!mode64 && !out_rex && !out_ud));

    // R7
    seg_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 4'd8) |-> (out_ud == mode64));

    // R8
    fsgs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 4'd9) |-> (out_esc && !out_ud));

    // R9
    bcd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 4'd10) |-> (out_ud == mode64));

    // R12
    flags_ah_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 4'd11) |-> (out_ud == (mode64 && !lahf_en)));

    // R10
    inc_rm_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 4'd4) |-> (out_opcode == 8'hFF && !out_ud && out_len >= 4'd2));

endmodule

bind x86_mode_classifier xmc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .mode64     (mode64),
    .lahf_en    (lahf_en),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_opcode (out_opcode),
    .out_esc    (out_esc),
    .out_class  (out_class),
    .out_len    (out_len),
    .out_ud     (out_ud),
    .out_rex    (out_rex)
);

// File: tb/x86_mode_classifier_test.sv
// Scoreboard bench: the driver queues expected records, the monitor compares outputs.
module x86_mode_classifier_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       mode64 = 1'b0;
    logic       lahf_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_opcode;
    logic       out_esc;
    logic [3:0] out_class;
    logic [3:0] out_len;
    logic       out_ud, out_opsz, out_adsz, out_rex;
    logic [3:0] out_wrxb;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // opcode, esc, class, len, ud, opsz, adsz, rex, wrxb
    logic [24:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    x86_mode_classifier uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .mode64(mode64), .lahf_en(lahf_en),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
        .out_esc(out_esc), .out_class(out_class), .out_len(out_len), .out_ud(out_ud),
        .out_opsz(out_opsz), .out_adsz(out_adsz), .out_rex(out_rex), .out_wrxb(out_wrxb)
    );

    task automatic expect_rec(input string tag, input logic [7:0] opc, input logic esc,
                              input logic [3:0] cls, input logic [3:0] len, input logic ud,
                              input logic opsz, input logic adsz, input logic rex,
                              input logic [3:0] wrxb);
        exp_q.push_back({opc, esc, cls, len, ud, opsz, adsz, rex, wrxb});
        tag_q.push_back(tag);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic ok, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each taken record against the queue head
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            logic [24:0] act;
            act = {out_opcode, out_esc, out_class, out_len, out_ud, out_opsz, out_adsz,
                   out_rex, out_wrxb};
            if (exp_q.size() == 0) begin
                check("unexpected record", 1'b0, {7'b0, act}, 32'h0);
            end else begin
                logic [24:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, act == e, {7'b0, act}, {7'b0, e});
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<50000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset out_valid", out_valid == 1'b0, {31'b0, out_valid}, 0);
        check("R1 reset in_ready", in_ready == 1'b1, {31'b0, in_ready}, 1);

        // ---- 32-bit mode ----
        expect_rec("R3 inc 40", 8'h40, 0, 4'd1, 4'd1, 0, 0, 0, 0, 4'h0); put(8'h40);
        expect_rec("R3 dec 4F", 8'h4F, 0, 4'd1, 4'd1, 0, 0, 0, 0, 4'h0); put(8'h4F);
        expect_rec("R4 66 40 legacy", 8'h40, 0, 4'd1, 4'd2, 0, 1, 0, 0, 4'h0);
        put(8'h66); put(8'h40);
        expect_rec("R6 arpl", 8'h63, 0, 4'd5, 4'd2, 0, 0, 0, 0, 4'h0); put(8'h63); put(8'hC1);
        expect_rec("R7 push es legacy", 8'h06, 0, 4'd8, 4'd1, 0, 0, 0, 0, 4'h0); put(8'h06);
        expect_rec("R9 daa legacy", 8'h27, 0, 4'd10, 4'd1, 0, 0, 0, 0, 4'h0); put(8'h27);
        expect_rec("R9 aam imm legacy", 8'hD4, 0, 4'd10, 4'd2, 0, 0, 0, 0, 4'h0);
        put(8'hD4); put(8'h0A);
        expect_rec("R12 lahf legacy", 8'h9F, 0, 4'd11, 4'd1, 0, 0, 0, 0, 4'h0); put(8'h9F);
        expect_rec("R11 mov imm32 legacy", 8'hB8, 0, 4'd3, 4'd5, 0, 0, 0, 0, 4'h0);
        put(8'hB8); put(8'h39); put(8'h30); put(8'h00); put(8'h00);
        expect_rec("R11 mov imm16", 8'hB8, 0, 4'd3, 4'd4, 0, 1, 0, 0, 4'h0);
        put(8'h66); put(8'hB8); put(8'h34); put(8'h12);
        expect_rec("R10 ff /0", 8'hFF, 0, 4'd4, 4'd2, 0, 0, 0, 0, 4'h0); put(8'hFF); put(8'hC0);
        expect_rec("R10 ff /1", 8'hFF, 0, 4'd0, 4'd2, 0, 0, 0, 0, 4'h0); put(8'hFF); put(8'hC8);
        expect_rec("R8 push fs legacy", 8'hA0, 1, 4'd9, 4'd2, 0, 0, 0, 0, 4'h0);
        put(8'h0F); put(8'hA0);
        expect_rec("R4 addr prefix", 8'h90, 0, 4'd2, 4'd2, 0, 0, 1, 0, 4'h0);
        put(8'h67); put(8'h90);
        idle(); drain();

        // ---- 64-bit mode ----
        mode64 = 1'b1;
        expect_rec("R4 66 40 90", 8'h90, 0, 4'd2, 4'd3, 0, 1, 0, 1, 4'h0);
        put(8'h66); put(8'h40); put(8'h90);
        expect_rec("R2 rex bits", 8'h90, 0, 4'd0, 4'd2, 0, 0, 0, 1, 4'hB); put(8'h4B); put(8'h90);
        expect_rec("R3 40 is rex in 64", 8'h90, 0, 4'd2, 4'd2, 0, 0, 0, 1, 4'h0);
        put(8'h40); put(8'h90);
        expect_rec("R5 rex dropped", 8'h90, 0, 4'd2, 4'd3, 0, 1, 0, 0, 4'h0);
        put(8'h48); put(8'h66); put(8'h90);
        expect_rec("R6 movsxd", 8'h63, 0, 4'd6, 4'd3, 0, 0, 0, 1, 4'h8);
        put(8'h48); put(8'h63); put(8'hC1);
        expect_rec("R6 movd no W", 8'h63, 0, 4'd7, 4'd2, 0, 0, 0, 0, 4'h0); put(8'h63); put(8'hC1);
        expect_rec("R7 pop ds 64", 8'h1F, 0, 4'd8, 4'd1, 1, 0, 0, 0, 4'h0); put(8'h1F);
        expect_rec("R7 push cs 64", 8'h0E, 0, 4'd8, 4'd1, 1, 0, 0, 0, 4'h0); put(8'h0E);
        expect_rec("R8 pop gs 64", 8'hA9, 1, 4'd9, 4'd2, 0, 0, 0, 0, 4'h0); put(8'h0F); put(8'hA9);
        expect_rec("R9 aad 64", 8'hD5, 0, 4'd10, 4'd1, 1, 0, 0, 0, 4'h0); put(8'hD5);
        expect_rec("R9 after fault", 8'h90, 0, 4'd2, 4'd1, 0, 0, 0, 0, 4'h0); put(8'h90);
        expect_rec("R11 mov imm64", 8'hB8, 0, 4'd3, 4'd10, 0, 0, 0, 1, 4'h8);
        put(8'h48); put(8'hB8);
        for (int i = 0; i < 8; i++) put(8'(i));
        expect_rec("R11 mov imm32 64", 8'hB8, 0, 4'd3, 4'd5, 0, 0, 0, 0, 4'h0);
        put(8'hB8); put(8'h39); put(8'h30); put(8'h00); put(8'h00);
        expect_rec("R10 ff /0 64", 8'hFF, 0, 4'd4, 4'd2, 0, 0, 0, 0, 4'h0); put(8'hFF); put(8'hC0);
        expect_rec("R12 sahf fault", 8'h9E, 0, 4'd11, 4'd1, 1, 0, 0, 0, 4'h0); put(8'h9E);
        idle(); drain();
        lahf_en = 1'b1;
        expect_rec("R12 lahf enabled", 8'h9F, 0, 4'd11, 4'd1, 0, 0, 0, 0, 4'h0); put(8'h9F);
        idle(); drain();

        // R13: flush a partial instruction
        put(8'h66); put(8'hB8); put(8'h39);
        @(negedge clk); in_valid = 1'b0; flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        expect_rec("R13 clean after flush", 8'h90, 0, 4'd2, 4'd1, 0, 0, 0, 0, 4'h0);
        put(8'h90); idle(); drain();

        // R14: backpressure holds record
        @(posedge clk); #1 out_ready = 1'b0;
        expect_rec("R14 held record", 8'h90, 0, 4'd2, 4'd1, 0, 0, 0, 0, 4'h0);
        put(8'h90); idle();
        repeat (3) @(negedge clk);
        check("R14 valid held", out_valid == 1'b1, {31'b0, out_valid}, 1);
        check("R14 ready low", in_ready == 1'b0, {31'b0, in_ready}, 0);
        @(posedge clk); #1 out_ready = 1'b1;
        drain();

        // R13: flush drops a pending record
        @(posedge clk); #1 out_ready = 1'b0;
        put(8'h90); idle();
        flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        check("R13 pending dropped", out_valid == 1'b0, {31'b0, out_valid}, 0);
        @(posedge clk); #1 out_ready = 1'b1;
        repeat (4) @(negedge clk);

        check("R14 queue empty", exp_q.size() == 0, exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule